// File: doc/BRIEF.md
# Power-Up Strap Configuration Latch

This block reads a set of board straps while the power-up reset is held and turns them into steady enable levels for the peripheral modules of the chip. The straps share pins with signals that become chip selects and address lines once the chip is running. While reset is asserted, those drivers are tri-stated, so pull-up or strap resistors decide the level that is seen. A pin that reads high counts as not asserted.

Four one-bit straps are sampled. These are the parallel-bus selection strap and the chip-select pins of the high-speed instrument-bus, low-speed instrument-bus and serial controllers. A two-bit address strap is sampled as well. The block keeps the levels seen at the last clock edge of reset. At the first clock edge after release it loads the decoded enables and the configuration index into output registers. These registers then hold their values until reset is asserted again.

The mutual exclusion between the SCSI and high-speed instrument-bus modules is part of the decode. The rule that register 5 is kept only in configuration #1 is also part of the decode.

Top module: `strap_cfg_sampler`

## Requirements
- R1: While `por_n` is low at a clock edge, the outputs after that edge are cleared: every enable is 0, `reg5_keep` is 0 and `cfg_idx` is 0.
- R2: The strap levels used are those present at the last rising clock edge with `por_n` low. The decoded outputs appear after the first rising edge with `por_n` high.
- R3: `scsi_en` is 1 only when the selection strap was low and the high-speed chip-select strap was high.
- R4: `hs_bus_en` is 1 only when the selection strap was high and the high-speed chip-select strap was high. A low high-speed chip-select strap disables both `hs_bus_en` and `scsi_en`.
- R5: `ls_bus_en` is 1 only when the low-speed chip-select strap was high and the address strap was 11 (configuration #1).
- R6: `reg5_keep` is 1 exactly when the address strap was 11, whatever the low-speed chip-select strap was.
- R7: `ser_en` is 1 exactly when the serial chip-select strap was high.
- R8: `cfg_idx` equals the configuration number minus one. Address strap 11 gives 0 (#1), 10 gives 1 (#2), 01 gives 2 (#3) and 00 gives 3 (#4).
- R9: After release, changes on any strap pin have no effect on the outputs until `por_n` goes low again.
- R10: `scsi_en` and `hs_bus_en` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, synchronous to `clk` |
| bus_sel_strap_n | input | 1 | Selection strap; low selects SCSI |
| hs_cs_strap_n | input | 1 | High-speed instrument-bus chip-select pin read as a strap |
| ls_cs_strap_n | input | 1 | Low-speed instrument-bus chip-select pin read as a strap |
| ser_cs_strap_n | input | 1 | Serial controller chip-select pin read as a strap |
| addr_strap | input | CFG_W | Address pins read as the configuration strap |
| scsi_en | output | 1 | Enable for the SCSI module |
| hs_bus_en | output | 1 | Enable for the high-speed instrument-bus module |
| ls_bus_en | output | 1 | Enable for the low-speed instrument-bus module |
| ser_en | output | 1 | Enable for the serial module |
| reg5_keep | output | 1 | Register 5 is present |
| cfg_idx | output | CFG_W | Configuration number minus one |

## Verification
A wrong captured strap shows up as a wrong enable or index one clock edge after `por_n` rises. A capture register that keeps tracking the pins after release shows up as outputs that follow the bench's random pin toggling during the run phase. A clear path that is missing shows up as stale enables on the first sample taken during the next reset.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;

    localparam int CFG_W_DEF = 2;

    // straps as read from the pins, all active low
    typedef struct packed {
        logic sel_n;
        logic hs_cs_n;
        logic ls_cs_n;
        logic ser_cs_n;
    } strap_pins_t;

    typedef struct packed {
        logic scsi;
        logic hs_bus;
        logic ls_bus;
        logic ser;
        logic reg5;
    } module_en_t;

    localparam module_en_t EN_NONE = '{default: 1'b0};

    // a high pin (pulled up, floating) means "not asserted"
    function automatic module_en_t decode_en(strap_pins_t p, logic first_cfg);
        module_en_t e;
        e.scsi   = !p.sel_n &&  p.hs_cs_n;
        e.hs_bus =  p.sel_n &&  p.hs_cs_n;
        e.ls_bus =  p.ls_cs_n && first_cfg;
        e.ser    =  p.ser_cs_n;
        e.reg5   =  first_cfg;
        return e;
    endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import strap_cfg_pkg::*;
#(
    parameter int CFG_W = CFG_W_DEF
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  strap_pins_t          pins_i,
    input  logic [CFG_W-1:0]     addr_i,
    output strap_pins_t          pins_q,
    output logic [CFG_W-1:0]     addr_q,
    output logic                 live_q
);

    // track the pins while reset holds; freeze on release
    always_ff @(posedge clk) begin
        if (!por_n) begin
            pins_q <= pins_i;
            addr_q <= addr_i;
        end
        live_q <= por_n;
    end

endmodule

// File: rtl/strap_decode.sv
module strap_decode
    import strap_cfg_pkg::*;
#(
    parameter int CFG_W = CFG_W_DEF
) (
    input  strap_pins_t          pins,
    input  logic [CFG_W-1:0]     addr,
    output module_en_t           en,
    output logic [CFG_W-1:0]     idx
);

    localparam logic [CFG_W-1:0] FIRST_CFG = '1;

    logic first_cfg;

    always_comb begin
        first_cfg = (addr == FIRST_CFG);
        en        = decode_en(pins, first_cfg);
        idx       = ~addr;
    end

endmodule

// File: rtl/cfg_hold.sv
module cfg_hold
    import strap_cfg_pkg::*;
#(
    parameter int CFG_W = CFG_W_DEF
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 live_q,
    input  module_en_t           en_d,
    input  logic [CFG_W-1:0]     idx_d,
    output module_en_t           en_q,
    output logic [CFG_W-1:0]     idx_q
);

    always_ff @(posedge clk) begin
        if (!por_n) begin
            en_q  <= EN_NONE;
            idx_q <= '0;
        end else if (!live_q) begin
            en_q  <= en_d;
            idx_q <= idx_d;
        end
    end

endmodule

// File: rtl/strap_cfg_sampler.sv
module strap_cfg_sampler
    import strap_cfg_pkg::*;
#(
    parameter int CFG_W = CFG_W_DEF
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             bus_sel_strap_n,
    input  logic             hs_cs_strap_n,
    input  logic             ls_cs_strap_n,
    input  logic             ser_cs_strap_n,
    input  logic [CFG_W-1:0] addr_strap,
    output logic             scsi_en,
    output logic             hs_bus_en,
    output logic             ls_bus_en,
    output logic             ser_en,
    output logic             reg5_keep,
    output logic [CFG_W-1:0] cfg_idx
);

    strap_pins_t      pins_in;
    strap_pins_t      pins_q;
    logic [CFG_W-1:0] addr_q;
    logic             live_q;
    module_en_t       en_d;
    module_en_t       en_q;
    logic [CFG_W-1:0] idx_d;

    assign pins_in = '{sel_n:    bus_sel_strap_n,
                       hs_cs_n:  hs_cs_strap_n,
                       ls_cs_n:  ls_cs_strap_n,
                       ser_cs_n: ser_cs_strap_n};

    strap_capture #(.CFG_W(CFG_W)) u_cap (
        .clk    (clk),
        .por_n  (por_n),
        .pins_i (pins_in),
        .addr_i (addr_strap),
        .pins_q (pins_q),
        .addr_q (addr_q),
        .live_q (live_q)
    );

    strap_decode #(.CFG_W(CFG_W)) u_dec (
        .pins (pins_q),
        .addr (addr_q),
        .en   (en_d),
        .idx  (idx_d)
    );

    cfg_hold #(.CFG_W(CFG_W)) u_hold (
        .clk    (clk),
        .por_n  (por_n),
        .live_q (live_q),
        .en_d   (en_d),
        .idx_d  (idx_d),
        .en_q   (en_q),
        .idx_q  (cfg_idx)
    );

    assign scsi_en   = en_q.scsi;
    assign hs_bus_en = en_q.hs_bus;
    assign ls_bus_en = en_q.ls_bus;
    assign ser_en    = en_q.ser;
    assign reg5_keep = en_q.reg5;

endmodule

// File: rtl/strap_cfg_sampler_chk.sv
module strap_cfg_sampler_chk #(
    parameter int CFG_W = 2
) (
    input logic             clk,
    input logic             por_n,
    input logic             scsi_en,
    input logic             hs_bus_en,
    input logic             ls_bus_en,
    input logic             ser_en,
    input logic             reg5_keep,
    input logic [CFG_W-1:0] cfg_idx
);

    logic [1:0] age = 2'd0;
    logic       armed;

    always_ff @(posedge clk) begin
        if (age != 2'd3) age <= age + 2'd1;
    end
    assign armed = (age == 2'd3);

    logic [CFG_W+4:0] outs;
    assign outs = {scsi_en, hs_bus_en, ls_bus_en, ser_en, reg5_keep, cfg_idx};

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (!armed)
        !por_n |=> (outs == '0));

    // R9
    hold_after_release_chk: assert property (@(posedge clk) disable iff (!armed)
        (por_n && $past(por_n)) |=> $stable(outs));

    // R10
    bus_exclusive_chk: assert property (@(posedge clk) disable iff (!armed)
        !(scsi_en && hs_bus_en));

    // R5
    ls_needs_first_cfg_chk: assert property (@(posedge clk) disable iff (!armed)
        ls_bus_en |-> (reg5_keep && cfg_idx == '0));

    // R6
    reg5_first_cfg_chk: assert property (@(posedge clk) disable iff (!armed)
        reg5_keep |-> (cfg_idx == '0));

endmodule

bind strap_cfg_sampler strap_cfg_sampler_chk #(.CFG_W(CFG_W)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .scsi_en   (scsi_en),
    .hs_bus_en (hs_bus_en),
    .ls_bus_en (ls_bus_en),
    .ser_en    (ser_en),
    .reg5_keep (reg5_keep),
    .cfg_idx   (cfg_idx)
);

// File: tb/tb_strap_cfg_sampler.sv
module tb_strap_cfg_sampler;

    localparam int CLK_PERIOD = 10;
    localparam int CFG_W = 2;
    localparam int OW = CFG_W + 5;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             bus_sel_strap_n = 1'b1;
    logic             hs_cs_strap_n = 1'b1;
    logic             ls_cs_strap_n = 1'b1;
    logic             ser_cs_strap_n = 1'b1;
    logic [CFG_W-1:0] addr_strap = '1;
    logic             scsi_en, hs_bus_en, ls_bus_en, ser_en, reg5_keep;
    logic [CFG_W-1:0] cfg_idx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_cfg_sampler #(.CFG_W(CFG_W)) dut (
        .clk(clk), .por_n(por_n),
        .bus_sel_strap_n(bus_sel_strap_n), .hs_cs_strap_n(hs_cs_strap_n),
        .ls_cs_strap_n(ls_cs_strap_n), .ser_cs_strap_n(ser_cs_strap_n),
        .addr_strap(addr_strap),
        .scsi_en(scsi_en), .hs_bus_en(hs_bus_en), .ls_bus_en(ls_bus_en),
        .ser_en(ser_en), .reg5_keep(reg5_keep), .cfg_idx(cfg_idx)
    );

    function automatic logic [OW-1:0] expect_outs(logic sel, logic hs, logic ls,
                                                  logic ser, logic [CFG_W-1:0] a);
        logic first;
        first = (a == '1);
        return {(!sel && hs), (sel && hs), (ls && first), ser, first, ~a};
    endfunction

    function automatic logic [OW-1:0] actual_outs();
        return {scsi_en, hs_bus_en, ls_bus_en, ser_en, reg5_keep, cfg_idx};
    endfunction

    task automatic check(logic [OW-1:0] exp, string req);
        checks++;
        if (actual_outs() !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, actual_outs(), exp);
        end
    endtask

    task automatic scramble_pins();
        bus_sel_strap_n = 1'($urandom);
        hs_cs_strap_n   = 1'($urandom);
        ls_cs_strap_n   = 1'($urandom);
        ser_cs_strap_n  = 1'($urandom);
        addr_strap      = CFG_W'($urandom);
    endtask

    task automatic trial(logic sel, logic hs, logic ls, logic ser,
                         logic [CFG_W-1:0] a, string req);
        @(negedge clk);
        por_n = 1'b0;
        scramble_pins();
        repeat (2) begin
            @(negedge clk);
            scramble_pins();
        end
        check('0, "R1 reset clears");
        bus_sel_strap_n = sel; hs_cs_strap_n = hs;
        ls_cs_strap_n = ls; ser_cs_strap_n = ser; addr_strap = a;
        @(negedge clk);
        // last low edge captured the straps; release and drive pins as outputs
        por_n = 1'b1;
        scramble_pins();
        @(negedge clk);
        check(expect_outs(sel, hs, ls, ser, a), req);
        repeat (3) begin
            scramble_pins();
            @(negedge clk);
        end
        check(expect_outs(sel, hs, ls, ser, a), "R9 pins ignored after release");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check('0, "R1 initial reset state");

        // directed: selection and high-speed chip-select combinations
        trial(1'b0, 1'b1, 1'b1, 1'b1, 2'b11, "R3 scsi chosen R2");
        trial(1'b1, 1'b1, 1'b1, 1'b1, 2'b11, "R4 hs bus chosen");
        trial(1'b0, 1'b0, 1'b1, 1'b1, 2'b11, "R4 hs cs low kills both R10");
        trial(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, "R4 hs cs low with sel high");
        // directed: configuration numbers
        trial(1'b1, 1'b1, 1'b1, 1'b1, 2'b10, "R8 cfg 2 R5 ls absent");
        trial(1'b1, 1'b1, 1'b1, 1'b1, 2'b01, "R8 cfg 3 R6 no reg5");
        trial(1'b1, 1'b1, 1'b1, 1'b1, 2'b00, "R8 cfg 4");
        trial(1'b1, 1'b1, 1'b0, 1'b1, 2'b11, "R6 reg5 kept with ls disabled R5");
        trial(1'b1, 1'b1, 1'b0, 1'b1, 2'b10, "R6 reg5 absent cfg 2 ls cs low");
        trial(1'b1, 1'b1, 1'b1, 1'b0, 2'b11, "R7 serial disabled");

        for (int i = 0; i < 40; i++) begin
            trial(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  CFG_W'($urandom), "R2 R3 R4 R5 R6 R7 R8 R10 random");
        end

        // R1 mid-run reset clears held outputs
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        check('0, "R1 clear on re-entry");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule